// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block takes one 32-bit instruction word each cycle and decides which floating-point operation it names. The word can be a displacement or indexed load or store of a floating value, a single- or double-precision arithmetic operation, a compare, a conversion or move, or an operation on the floating-point status register. Any other word is reported as illegal. For a legal word the block gives a one-hot operation vector, an operand-format tag that says which register and immediate fields the operation uses, every extracted field, an update-base flag and a record flag. Address generation, register file reads and the arithmetic are done by later stages.

Decoding works in two levels. The primary opcode in bits 31:26 picks a group. Inside the indexed group a 10-bit extended opcode in bits 10:1 picks the operation. Inside the single-precision group a 5-bit extended opcode in bits 5:1 picks it. Inside the double group, instruction bit 5 chooses between the 5-bit three-source table and the 10-bit table. Some forms are also illegal when the base register field is zero. An illegal word drives every valid and enable output low, so a downstream stage never acts on it. With the default parameter setting the outputs are registered, giving one cycle of latency.

Top module: `fpdec_top`

## Requirements
- R1: Primary opcodes 48 to 55 decode as displacement loads and stores. Bits 2:1 of the opcode select the operation: 0 single load (op bit 0), 1 double load (op bit 1), 2 single store (op bit 2), 3 double store (op bit 3). An odd opcode sets `update_o`. The displacement output is bits 15:0 sign-extended.
- R2: A displacement update form (odd opcode) whose base field, bits 20:16, is zero is illegal. The non-update form with base zero is legal.
- R3: Primary opcode 31 with extended opcode bits 10:1 decodes the indexed transfers: 535 single load, 567 single load with update, 599 double load, 631 double load with update, 663 single store, 695 single store with update, 727 double store, 759 double store with update, and 983 integer-word store (op bit 4). A non-update indexed form with base field zero is illegal; an update indexed form with base zero is legal.
- R4: Primary opcode 59 with bits 5:1 decodes these operations and sets `single_o`: 18 divide (op 5), 20 subtract (op 6), 21 add (op 7), 22 square root (op 8), 24 reciprocal estimate (op 9), 25 multiply (op 10), 28 multiply-subtract (op 11), 29 multiply-add (op 12), 30 negated multiply-subtract (op 13), 31 negated multiply-add (op 14). Every other value is illegal.
- R5: Primary opcode 63 with bit 5 set uses the same 5-bit codes with `single_o` low, except that 24 is illegal. It adds 23 select (op 15) and 26 reciprocal square-root estimate (op 16).
- R6: Primary opcode 63 with bit 5 clear uses bits 10:1: 0 unordered compare (op 17), 32 ordered compare (op 18), 12 round to single (op 19), 14 convert to integer word (op 20), 15 convert toward zero (op 21), 40 negate (op 22), 72 move (op 23), 136 negative absolute (op 24), 264 absolute (op 25), 38 set status bit (op 26), 70 clear status bit (op 27), 64 copy status field to condition field (op 28), 134 status field immediate (op 29), 583 read status (op 30), 711 write status fields (op 31).
- R7: The field outputs are always the raw slices of the word. Target is bits 25:21, A is 20:16, B is 15:11, C is 10:6, the condition field is 25:23, the source status field is 20:18, the 4-bit immediate is 15:12 and the field mask is 24:17.
- R8: `fmt_o` names the operand form: 1 target,A,B; 2 target,A,C (multiply); 3 target,A,B,C (fused ops, select); 4 displacement; 5 displacement with update; 6 indexed; 7 indexed with update; 8 target,B; 9 target only; 10 condition field,A,B; 11 condition field,status field; 12 bit number in target field; 13 condition field with 4-bit immediate; 14 mask with B; 0 for an illegal word.
- R9: `record_o` equals bit 0 only for a legal word with primary opcode 59 or 63. It is low for loads, stores and illegal words.
- R10: Any primary or extended opcode not listed above sets `illegal_o`. An illegal word drives `valid_o`, `op_oh_o`, `fmt_o`, `single_o`, `update_o` and `record_o` to zero.
- R11: For a legal word, `valid_o` is high and exactly one bit of `op_oh_o` is set.
- R12: With `OUT_REG` = 1 the outputs show the word sampled at the previous rising edge and hold steady between edges. A synchronous reset with `rst_n` low clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| illegal_o | output | 1 | Word is not a recognised floating-point instruction |
| valid_o | output | 1 | Word decoded to a legal operation |
| op_oh_o | output | NUM_OPS | One-hot operation vector |
| fmt_o | output | 4 | Operand-format tag |
| single_o | output | 1 | Single-precision arithmetic group |
| update_o | output | 1 | Base register is written back |
| record_o | output | 1 | Copy status summary into condition field 1 |
| rt_o | output | 5 | Target register field |
| ra_o | output | 5 | A / base register field |
| rb_o | output | 5 | B / index register field |
| rc_o | output | 5 | C register field |
| crf_o | output | 3 | Condition field number |
| sfld_o | output | 3 | Source status field |
| imm4_o | output | 4 | 4-bit status immediate |
| mask_o | output | 8 | Status field mask |
| disp_o | output | DISP_W | Sign-extended displacement |

## Verification
The assertions check on every cycle that an illegal result never carries an operation, format or enable. They also check that the operation vector is one-hot exactly when the result is valid, and that update forms never go out with a zero base where that is forbidden. They check that record and single-precision flags appear only on the matching operation classes, that an unknown primary opcode always ends as illegal one cycle later, and that reset leaves the outputs cleared. The bench scenarios show the rest. Each extended-opcode value must map to the right operation and format. The base-zero quirk must go opposite ways for indexed and displacement update forms, opcode 24 must be accepted in one group and refused in the other, and the field slices and the sign extension of the displacement must come out correct.

// File: rtl/fpdec_pkg.sv
// Package: shared encodings for the floating-point instruction decoder.
// Assumes a 32-bit instruction word with the primary opcode in bits 31:26.
package fpdec_pkg;

    localparam int NUM_OPS = 32;
    localparam int OP_W    = $clog2(NUM_OPS);

    // Primary opcode groups
    localparam logic [5:0] PRI_INDEXED = 6'd31;
    localparam logic [5:0] PRI_ARITH_S = 6'd59;
    localparam logic [5:0] PRI_ARITH_D = 6'd63;

    // Operation index; bit position in the one-hot vector
    typedef enum logic [OP_W-1:0] {
        OP_LOAD_S   = 5'd0,  OP_LOAD_D   = 5'd1,  OP_STORE_S  = 5'd2,
        OP_STORE_D  = 5'd3,  OP_STORE_IW = 5'd4,  OP_DIV      = 5'd5,
        OP_SUB      = 5'd6,  OP_ADD      = 5'd7,  OP_SQRT     = 5'd8,
        OP_RECIP    = 5'd9,  OP_MUL      = 5'd10, OP_MSUB     = 5'd11,
        OP_MADD     = 5'd12, OP_NMSUB    = 5'd13, OP_NMADD    = 5'd14,
        OP_SELECT   = 5'd15, OP_RSQRT    = 5'd16, OP_CMP_UN   = 5'd17,
        OP_CMP_ORD  = 5'd18, OP_RND_S    = 5'd19, OP_CVT_I    = 5'd20,
        OP_CVT_IZ   = 5'd21, OP_NEG      = 5'd22, OP_MOVE     = 5'd23,
        OP_NABS     = 5'd24, OP_ABS      = 5'd25, OP_SBIT_SET = 5'd26,
        OP_SBIT_CLR = 5'd27, OP_SFLD_CR  = 5'd28, OP_SFLD_IMM = 5'd29,
        OP_STAT_RD  = 5'd30, OP_STAT_WR  = 5'd31
    } op_e;

    // Operand-format tag
    typedef enum logic [3:0] {
        FMT_NONE    = 4'd0,  FMT_TAB     = 4'd1,  FMT_TAC     = 4'd2,
        FMT_TABC    = 4'd3,  FMT_DISP    = 4'd4,  FMT_DISP_UP = 4'd5,
        FMT_IDX     = 4'd6,  FMT_IDX_UP  = 4'd7,  FMT_TB      = 4'd8,
        FMT_T       = 4'd9,  FMT_CMP     = 4'd10, FMT_CRSF    = 4'd11,
        FMT_BITNUM  = 4'd12, FMT_IMM4    = 4'd13, FMT_MASKB   = 4'd14
    } fmt_e;

    // Classification result
    typedef struct packed {
        logic legal;
        op_e  op;
        fmt_e fmt;
        logic single;
        logic update;
        logic record;
    } cls_t;

endpackage

// File: rtl/fpdec_fields.sv
// Field extractor: slices the register, condition, immediate and mask
// fields out of the low 26 bits of the word. Assumes DISP_W > 16.
module fpdec_fields #(
    parameter int DISP_W = 32
) (
    input  logic [25:0]       body_i,
    output logic [4:0]        rt_o,
    output logic [4:0]        ra_o,
    output logic [4:0]        rb_o,
    output logic [4:0]        rc_o,
    output logic [2:0]        crf_o,
    output logic [2:0]        sfld_o,
    output logic [3:0]        imm4_o,
    output logic [7:0]        mask_o,
    output logic [DISP_W-1:0] disp_o
);
    localparam int EXT_W = DISP_W - 16;

    // Pure wiring of the fixed bit slices
    always_comb begin
        rt_o   = body_i[25:21];
        ra_o   = body_i[20:16];
        rb_o   = body_i[15:11];
        rc_o   = body_i[10:6];
        crf_o  = body_i[25:23];
        sfld_o = body_i[20:18];
        imm4_o = body_i[15:12];
        mask_o = body_i[24:17];
        disp_o = {{EXT_W{body_i[15]}}, body_i[15:0]};
    end
endmodule

// File: rtl/fpdec_classify.sv
// Opcode classifier: two-level decode of the primary and extended opcode
// into an operation, a format tag and flags. Assumes the caller passes
// bits 31:26, bits 10:1, bit 0 and a base-field-is-zero indication.
module fpdec_classify
    import fpdec_pkg::*;
(
    input  logic [5:0] prim_i,
    input  logic [9:0] xo_i,
    input  logic       rec_bit_i,
    input  logic       base_zero_i,
    output cls_t       cls_o
);
    // 5-bit three-source table; the double group drops 24 and adds 23/26
    function automatic logic arith5(input logic [4:0] x, input logic dbl,
                                    output op_e o, output fmt_e f);
        logic ok;
        ok = 1'b1;
        o  = OP_DIV;
        f  = FMT_TAB;
        case (x)
            5'd18: o = OP_DIV;
            5'd20: o = OP_SUB;
            5'd21: o = OP_ADD;
            5'd22: o = OP_SQRT;
            5'd24: begin o = OP_RECIP;  ok = !dbl; end
            5'd25: begin o = OP_MUL;    f = FMT_TAC;  end
            5'd28: begin o = OP_MSUB;   f = FMT_TABC; end
            5'd29: begin o = OP_MADD;   f = FMT_TABC; end
            5'd30: begin o = OP_NMSUB;  f = FMT_TABC; end
            5'd31: begin o = OP_NMADD;  f = FMT_TABC; end
            5'd23: begin o = OP_SELECT; f = FMT_TABC; ok = dbl; end
            5'd26: begin o = OP_RSQRT;  ok = dbl; end
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    // 10-bit table of the double group (bit 5 clear)
    function automatic logic xtab(input logic [9:0] x,
                                  output op_e o, output fmt_e f);
        logic ok;
        ok = 1'b1;
        o  = OP_MOVE;
        f  = FMT_TB;
        case (x)
            10'd0:   begin o = OP_CMP_UN;   f = FMT_CMP;    end
            10'd32:  begin o = OP_CMP_ORD;  f = FMT_CMP;    end
            10'd12:  o = OP_RND_S;
            10'd14:  o = OP_CVT_I;
            10'd15:  o = OP_CVT_IZ;
            10'd40:  o = OP_NEG;
            10'd72:  o = OP_MOVE;
            10'd136: o = OP_NABS;
            10'd264: o = OP_ABS;
            10'd38:  begin o = OP_SBIT_SET; f = FMT_BITNUM; end
            10'd70:  begin o = OP_SBIT_CLR; f = FMT_BITNUM; end
            10'd64:  begin o = OP_SFLD_CR;  f = FMT_CRSF;   end
            10'd134: begin o = OP_SFLD_IMM; f = FMT_IMM4;   end
            10'd583: begin o = OP_STAT_RD;  f = FMT_T;      end
            10'd711: begin o = OP_STAT_WR;  f = FMT_MASKB;  end
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Group select, per-group decode, then illegal clean-up
    always_comb begin
        op_e  o;
        fmt_e f;
        cls_o = '0;
        o = OP_LOAD_S;
        f = FMT_NONE;
        case (prim_i)
            6'd48, 6'd49, 6'd50, 6'd51, 6'd52, 6'd53, 6'd54, 6'd55: begin
                cls_o.op     = op_e'({3'b000, prim_i[2:1]});
                cls_o.update = prim_i[0];
                cls_o.fmt    = prim_i[0] ? FMT_DISP_UP : FMT_DISP;
                cls_o.legal  = !(prim_i[0] && base_zero_i);
            end
            PRI_INDEXED: begin
                if (xo_i[9:8] == 2'b10 && xo_i[4:0] == 5'b10111) begin
                    cls_o.op     = op_e'({3'b000, xo_i[7:6]});
                    cls_o.update = xo_i[5];
                    cls_o.fmt    = xo_i[5] ? FMT_IDX_UP : FMT_IDX;
                    cls_o.legal  = xo_i[5] || !base_zero_i;
                end else if (xo_i == 10'd983) begin
                    cls_o.op    = OP_STORE_IW;
                    cls_o.fmt   = FMT_IDX;
                    cls_o.legal = !base_zero_i;
                end
            end
            PRI_ARITH_S: begin
                cls_o.legal  = arith5(xo_i[4:0], 1'b0, o, f);
                cls_o.op     = o;
                cls_o.fmt    = f;
                cls_o.single = 1'b1;
            end
            PRI_ARITH_D: begin
                if (xo_i[4]) cls_o.legal = arith5(xo_i[4:0], 1'b1, o, f);
                else         cls_o.legal = xtab(xo_i, o, f);
                cls_o.op  = o;
                cls_o.fmt = f;
            end
            default: cls_o.legal = 1'b0;
        endcase
        cls_o.record = rec_bit_i &&
                       (prim_i == PRI_ARITH_S || prim_i == PRI_ARITH_D);
        if (!cls_o.legal) begin
            cls_o.fmt    = FMT_NONE;
            cls_o.single = 1'b0;
            cls_o.update = 1'b0;
            cls_o.record = 1'b0;
        end
    end
endmodule

// File: rtl/fpdec_top.sv
// Floating-point instruction decoder top. Classifies a 32-bit word,
// extracts its fields and, when OUT_REG is 1, registers all outputs.
// Assumes synchronous active-low reset and DISP_W > 16.
module fpdec_top
    import fpdec_pkg::*;
#(
    parameter bit OUT_REG = 1'b1,
    parameter int DISP_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        insn_i,
    output logic               illegal_o,
    output logic               valid_o,
    output logic [NUM_OPS-1:0] op_oh_o,
    output logic [3:0]         fmt_o,
    output logic               single_o,
    output logic               update_o,
    output logic               record_o,
    output logic [4:0]         rt_o,
    output logic [4:0]         ra_o,
    output logic [4:0]         rb_o,
    output logic [4:0]         rc_o,
    output logic [2:0]         crf_o,
    output logic [2:0]         sfld_o,
    output logic [3:0]         imm4_o,
    output logic [7:0]         mask_o,
    output logic [DISP_W-1:0]  disp_o
);
    cls_t               cls;
    logic [NUM_OPS-1:0] oh_d;
    logic [4:0]         rt_d, ra_d, rb_d, rc_d;
    logic [2:0]         crf_d, sfld_d;
    logic [3:0]         imm4_d;
    logic [7:0]         mask_d;
    logic [DISP_W-1:0]  disp_d;

    fpdec_classify u_cls (
        .prim_i      (insn_i[31:26]),
        .xo_i        (insn_i[10:1]),
        .rec_bit_i   (insn_i[0]),
        .base_zero_i (insn_i[20:16] == 5'd0),
        .cls_o       (cls)
    );

    fpdec_fields #(.DISP_W(DISP_W)) u_fld (
        .body_i (insn_i[25:0]),
        .rt_o   (rt_d),
        .ra_o   (ra_d),
        .rb_o   (rb_d),
        .rc_o   (rc_d),
        .crf_o  (crf_d),
        .sfld_o (sfld_d),
        .imm4_o (imm4_d),
        .mask_o (mask_d),
        .disp_o (disp_d)
    );

    // One-hot expansion, gated off for an illegal word
    always_comb begin
        oh_d = cls.legal ? (NUM_OPS'(1) << cls.op) : '0;
    end

    generate
        if (OUT_REG) begin : g_reg
            // Output stage: one cycle of latency, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    illegal_o <= 1'b0;  valid_o  <= 1'b0;  op_oh_o  <= '0;
                    fmt_o     <= '0;    single_o <= 1'b0;  update_o <= 1'b0;
                    record_o  <= 1'b0;  rt_o     <= '0;    ra_o     <= '0;
                    rb_o      <= '0;    rc_o     <= '0;    crf_o    <= '0;
                    sfld_o    <= '0;    imm4_o   <= '0;    mask_o   <= '0;
                    disp_o    <= '0;
                end else begin
                    illegal_o <= !cls.legal;  valid_o  <= cls.legal;
                    op_oh_o   <= oh_d;        fmt_o    <= cls.fmt;
                    single_o  <= cls.single;  update_o <= cls.update;
                    record_o  <= cls.record;  rt_o     <= rt_d;
                    ra_o      <= ra_d;        rb_o     <= rb_d;
                    rc_o      <= rc_d;        crf_o    <= crf_d;
                    sfld_o    <= sfld_d;      imm4_o   <= imm4_d;
                    mask_o    <= mask_d;      disp_o   <= disp_d;
                end
            end
        end else begin : g_comb
            // Pass-through variant: outputs follow the word directly
            always_comb begin
                illegal_o = !cls.legal;  valid_o  = cls.legal;
                op_oh_o   = oh_d;        fmt_o    = cls.fmt;
                single_o  = cls.single;  update_o = cls.update;
                record_o  = cls.record;  rt_o     = rt_d;
                ra_o      = ra_d;        rb_o     = rb_d;
                rc_o      = rc_d;        crf_o    = crf_d;
                sfld_o    = sfld_d;      imm4_o   = imm4_d;
                mask_o    = mask_d;      disp_o   = disp_d;
            end
        end
    endgenerate
endmodule

// File: rtl/fpdec_chk.sv
// Checker for fpdec_top: relations between the decoded outputs, plus
// latency and reset properties. Bound to every fpdec_top instance.
module fpdec_chk #(
    parameter bit OUT_REG = 1'b1,
    parameter int NUM_OPS = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [5:0]         prim,
    input logic               illegal_o,
    input logic               valid_o,
    input logic [NUM_OPS-1:0] op_oh_o,
    input logic [3:0]         fmt_o,
    input logic               single_o,
    input logic               update_o,
    input logic               record_o,
    input logic [4:0]         ra_o
);
    logic armed;

    // Marks that one clock edge has passed, so $past has a real value
    always_ff @(posedge clk) armed <= 1'b1;

    function automatic logic known_prim(input logic [5:0] p);
        return (p == 6'd31) || (p == 6'd59) || (p == 6'd63) ||
               (p >= 6'd48 && p <= 6'd55);
    endfunction

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!valid_o && op_oh_o == '0 && fmt_o == 4'd0 &&
                       !single_o && !update_o && !record_o));

    // R11
    onehot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(op_oh_o) == (valid_o ? 1 : 0));

    // R2
    disp_upd_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o == 4'd5) |-> (ra_o != 5'd0 && update_o));

    // R3
    idx_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o == 4'd6) |-> (ra_o != 5'd0 && !update_o));

    // R9
    record_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        record_o |-> (valid_o && op_oh_o[4:0] == 5'd0));

    // R4
    single_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_o |-> (|op_oh_o[14:5]));

    generate
        if (OUT_REG) begin : g_seq
            // R10
            unknown_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !known_prim($past(prim))) |-> illegal_o);

            // R12
            reset_clear_chk: assert property (@(posedge clk) disable iff (!armed)
                !$past(rst_n) |-> (!valid_o && !illegal_o && op_oh_o == '0));
        end else begin : g_comb
            // R10
            unknown_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !known_prim(prim) |-> illegal_o);
        end
    endgenerate
endmodule

bind fpdec_top fpdec_chk #(.OUT_REG(OUT_REG), .NUM_OPS(fpdec_pkg::NUM_OPS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .prim      (insn_i[31:26]),
    .illegal_o (illegal_o),
    .valid_o   (valid_o),
    .op_oh_o   (op_oh_o),
    .fmt_o     (fmt_o),
    .single_o  (single_o),
    .update_o  (update_o),
    .record_o  (record_o),
    .ra_o      (ra_o)
);

// File: tb/fpdec_top_tb_top.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// them one cycle later and compares every output.
module fpdec_top_tb_top;
    localparam int NOPS = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     insn = 32'h0;
    logic            illegal, valid, single, update, record;
    logic [NOPS-1:0] op_oh;
    logic [3:0]      fmt, imm4;
    logic [4:0]      rt, ra, rb, rc;
    logic [2:0]      crf, sfld;
    logic [7:0]      mask;
    logic [31:0]     disp;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [31:0] w;
        int          op;     // -1 means illegal
        int          fmt;
        bit          sp;
        bit          upd;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    fpdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .insn_i(insn),
        .illegal_o(illegal), .valid_o(valid), .op_oh_o(op_oh), .fmt_o(fmt),
        .single_o(single), .update_o(update), .record_o(record),
        .rt_o(rt), .ra_o(ra), .rb_o(rb), .rc_o(rc), .crf_o(crf),
        .sfld_o(sfld), .imm4_o(imm4), .mask_o(mask), .disp_o(disp)
    );

    function automatic logic [31:0] dform(int p, int t, int a, int d);
        return {p[5:0], t[4:0], a[4:0], d[15:0]};
    endfunction
    function automatic logic [31:0] xform(int p, int t, int a, int b, int xo, int rc0);
        return {p[5:0], t[4:0], a[4:0], b[4:0], xo[9:0], rc0[0]};
    endfunction
    function automatic logic [31:0] aform(int p, int t, int a, int b, int c, int xo, int rc0);
        return {p[5:0], t[4:0], a[4:0], b[4:0], c[4:0], xo[4:0], rc0[0]};
    endfunction

    task automatic send(logic [31:0] w, int op, int f, bit sp, bit upd, string tag);
        exp_t e;
        @(negedge clk);
        insn = w;
        e.w = w; e.op = op; e.fmt = f; e.sp = sp; e.upd = upd; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one cycle after the word was driven (R12 latency)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                bit ill, rec;
                logic [NOPS-1:0] oh;
                logic [31:0] dx;
                e   = q.pop_front();
                ill = (e.op < 0);
                oh  = ill ? '0 : (NOPS'(1) << e.op);
                rec = !ill && (e.w[31:26] == 6'd59 || e.w[31:26] == 6'd63) && e.w[0];
                n_tests++;
                if (illegal !== ill || valid !== !ill || op_oh !== oh ||
                    fmt !== 4'(ill ? 0 : e.fmt) || single !== (e.sp && !ill) ||
                    update !== (e.upd && !ill) || record !== rec) begin
                    n_fail++;
                    $display("FAIL %s w=%h ill=%0b/%0b val=%0b oh=%h/%h fmt=%0d/%0d sp=%0b/%0b upd=%0b/%0b rec=%0b/%0b",
                             e.tag, e.w, illegal, ill, valid, op_oh, oh, fmt, e.fmt,
                             single, e.sp, update, e.upd, record, rec);
                end
                dx = {{16{e.w[15]}}, e.w[15:0]};
                n_tests++;
                if (rt !== e.w[25:21] || ra !== e.w[20:16] || rb !== e.w[15:11] ||
                    rc !== e.w[10:6] || crf !== e.w[25:23] || sfld !== e.w[20:18] ||
                    imm4 !== e.w[15:12] || mask !== e.w[24:17] || disp !== dx) begin
                    n_fail++;
                    $display("FAIL R7 w=%h rt=%0d/%0d ra=%0d/%0d rb=%0d/%0d rc=%0d/%0d crf=%0d/%0d sf=%0d/%0d i4=%h/%h m=%h/%h d=%h/%h",
                             e.w, rt, e.w[25:21], ra, e.w[20:16], rb, e.w[15:11],
                             rc, e.w[10:6], crf, e.w[25:23], sfld, e.w[20:18],
                             imm4, e.w[15:12], mask, e.w[24:17], disp, dx);
                end
            end
        end
    end

    task automatic final_report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        final_report();
    end

    initial begin
        // R12 reset state, even with a legal word presented
        insn = dform(50, 1, 2, 3);
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if (valid !== 1'b0 || illegal !== 1'b0 || op_oh !== '0 || fmt !== 4'd0) begin
            n_fail++;
            $display("FAIL R12 reset val=%0b/0 ill=%0b/0 oh=%h/0 fmt=%0d/0", valid, illegal, op_oh, fmt);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 displacement forms
        send(dform(48, 3, 4, 16'h8001), 0, 4, 0, 0, "R1");
        send(dform(49, 7, 5, 16'h0010), 0, 5, 0, 1, "R1");
        send(dform(50, 1, 2, 16'h7ffe), 1, 4, 0, 0, "R1");
        send(dform(51, 9, 31, 16'hffff), 1, 5, 0, 1, "R1");
        send(dform(52, 2, 6, 16'h1234), 2, 4, 0, 0, "R1");
        send(dform(53, 2, 1, 16'h8000), 2, 5, 0, 1, "R1");
        send(dform(54, 0, 8, 16'h0004), 3, 4, 0, 0, "R1");
        send(dform(55, 4, 3, 16'hfff0), 3, 5, 0, 1, "R1");
        send(dform(48, 3, 0, 16'h0021), 0, 4, 0, 0, "R2");   // base 0 ok, bit0=1 no record (R9)
        send(dform(51, 3, 0, 16'h0020), -1, 0, 0, 0, "R2");
        send(dform(55, 3, 0, 16'h0020), -1, 0, 0, 0, "R2");

        // R3 indexed forms
        send(xform(31, 1, 2, 3, 535, 0), 0, 6, 0, 0, "R3");
        send(xform(31, 1, 2, 3, 567, 0), 0, 7, 0, 1, "R3");
        send(xform(31, 1, 2, 3, 599, 0), 1, 6, 0, 0, "R3");
        send(xform(31, 1, 2, 3, 631, 1), 1, 7, 0, 1, "R3");  // bit0 no record (R9)
        send(xform(31, 1, 2, 3, 663, 0), 2, 6, 0, 0, "R3");
        send(xform(31, 1, 2, 3, 695, 0), 2, 7, 0, 1, "R3");
        send(xform(31, 1, 2, 3, 727, 0), 3, 6, 0, 0, "R3");
        send(xform(31, 1, 2, 3, 759, 0), 3, 7, 0, 1, "R3");
        send(xform(31, 1, 2, 3, 983, 0), 4, 6, 0, 0, "R3");
        send(xform(31, 1, 0, 3, 599, 0), -1, 0, 0, 0, "R3");
        send(xform(31, 1, 0, 3, 983, 0), -1, 0, 0, 0, "R3");
        send(xform(31, 1, 0, 3, 631, 0), 1, 7, 0, 1, "R3");
        send(xform(31, 1, 2, 3, 536, 0), -1, 0, 0, 0, "R10");

        // R4 single group
        send(aform(59, 1, 2, 3, 4, 18, 0), 5, 1, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 20, 0), 6, 1, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 21, 1), 7, 1, 1, 0, "R4_R9");
        send(aform(59, 1, 2, 3, 4, 22, 0), 8, 1, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 24, 0), 9, 1, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 25, 0), 10, 2, 1, 0, "R4_R8");
        send(aform(59, 1, 2, 3, 4, 28, 0), 11, 3, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 29, 0), 12, 3, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 30, 0), 13, 3, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 31, 1), 14, 3, 1, 0, "R4");
        send(aform(59, 1, 2, 3, 4, 23, 1), -1, 0, 0, 0, "R4_R10");
        send(aform(59, 1, 2, 3, 4, 26, 0), -1, 0, 0, 0, "R4");

        // R5 double group, three-source table
        send(aform(63, 5, 6, 7, 8, 18, 0), 5, 1, 0, 0, "R5");
        send(aform(63, 5, 6, 7, 8, 21, 1), 7, 1, 0, 0, "R5_R9");
        send(aform(63, 5, 6, 7, 8, 25, 0), 10, 2, 0, 0, "R5");
        send(aform(63, 5, 6, 7, 8, 29, 0), 12, 3, 0, 0, "R5");
        send(aform(63, 5, 6, 7, 8, 23, 0), 15, 3, 0, 0, "R5");
        send(aform(63, 5, 6, 7, 8, 26, 0), 16, 1, 0, 0, "R5");
        send(aform(63, 5, 6, 7, 8, 24, 0), -1, 0, 0, 0, "R5");
        send(aform(63, 5, 6, 7, 8, 19, 0), -1, 0, 0, 0, "R5");

        // R6 double group, 10-bit table
        send(xform(63, 28, 6, 7, 0, 0), 17, 10, 0, 0, "R6");
        send(xform(63, 28, 6, 7, 32, 0), 18, 10, 0, 0, "R6");
        send(xform(63, 1, 0, 7, 12, 1), 19, 8, 0, 0, "R6");
        send(xform(63, 1, 0, 7, 14, 0), 20, 8, 0, 0, "R6");
        send(xform(63, 1, 0, 7, 15, 0), 21, 8, 0, 0, "R6");
        send(xform(63, 1, 0, 7, 40, 0), 22, 8, 0, 0, "R6");
        send(xform(63, 1, 0, 7, 72, 0), 23, 8, 0, 0, "R6");
        send(xform(63, 1, 0, 7, 136, 0), 24, 8, 0, 0, "R6");
        send(xform(63, 1, 0, 7, 264, 0), 25, 8, 0, 0, "R6");
        send(xform(63, 17, 0, 0, 38, 0), 26, 12, 0, 0, "R6_R8");
        send(xform(63, 17, 0, 0, 70, 0), 27, 12, 0, 0, "R6");
        send(xform(63, 12, 20, 0, 64, 0), 28, 11, 0, 0, "R6");
        send(xform(63, 12, 0, 18, 134, 0), 29, 13, 0, 0, "R6");
        send(xform(63, 9, 0, 0, 583, 1), 30, 9, 0, 0, "R6");
        send(xform(63, 30, 21, 4, 711, 0), 31, 14, 0, 0, "R6_R8");
        send(xform(63, 1, 2, 3, 1, 1), -1, 0, 0, 0, "R6_R10");

        // R10 unknown primary opcodes
        send(32'h0000_0001, -1, 0, 0, 0, "R10");
        send(dform(47, 1, 2, 3), -1, 0, 0, 0, "R10");
        send(dform(56, 1, 2, 3), -1, 0, 0, 0, "R10");
        send(aform(60, 1, 2, 3, 4, 21, 1), -1, 0, 0, 0, "R10");
        send(aform(58, 1, 2, 3, 4, 21, 0), 7 - 8, 0, 0, 0, "R10");
        send(aform(63, 5, 6, 7, 8, 21, 0), 7, 1, 0, 0, "R11");

        // R12: output holds until the next edge, then follows
        @(posedge clk);
        #1;
        @(negedge clk);
        insn = 32'h0;
        #1;
        n_tests++;
        if (valid !== 1'b1 || illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 hold val=%0b/1 ill=%0b/0", valid, illegal);
        end
        @(posedge clk);
        #1;
        n_tests++;
        if (illegal !== 1'b1 || valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 follow ill=%0b/1 val=%0b/0", illegal, valid);
        end
        final_report();
    end
endmodule